// File: doc/BRIEF.md
# Mirrored Bus Address Decoder with RAM Write Lock

This block sits on a 32-bit processor bus and sorts every access by address. Each access is assigned a target region: main RAM, boot ROM, scratchpad, I/O register page, the lock control register, or none. The block also produces the byte offset inside that region, so the memory behind it sees a local address. Main RAM has three mirror windows. In each window the same 2 MiB array repeats every 2 MiB across 8 MiB. The boot ROM has two mirror windows and cannot be written.

A word write of certain values to one fixed control address sets or clears a single write-lock flag. While the flag is set, RAM writes through any mirror are turned into unmapped accesses and are lost. A boot-time RAM test uses this. RAM reads are not affected by the flag. Decoding is combinational from the access fields and the flag. The flag itself is a register that changes on the clock edge of a qualifying write.

Top module: `mirror_decoder`

## Requirements
- R1: The RAM region (code 1) is selected for addresses 0x0000_0000 to 0x007F_FFFF, 0x8000_0000 to 0x807F_FFFF and 0xA000_0000 to 0xA07F_FFFF, for both reads and writes while unlocked. The offset is the address modulo 2 MiB.
- R2: Reads from 0x1FC0_0000 to 0x1FC7_FFFF and from 0xBFC0_0000 to 0xBFC7_FFFF select the ROM region (code 2), with the offset equal to the address modulo 512 KiB. Writes there are unmapped.
- R3: Reads and writes in the 4 KiB page at 0x1F80_0000 select the scratchpad region (code 3), with the offset equal to address bits 11:0.
- R4: Reads and writes in the 4 KiB page at 0x1F80_1000 select the I/O region (code 4), with the offset equal to address bits 11:0.
- R5: Only a word-size (size code 2) write to 0xFFFE_0130 selects the control region (code 5), with offset 0. Byte-size (code 0) or halfword-size (code 1) writes to that address are unmapped, and so are reads of it and writes to other addresses in that page. None of these change the lock flag.
- R6: A control write of data 0x800 or 0x804 sets the lock from the next clock edge. While the lock is set, RAM writes through all three mirrors are unmapped and RAM reads still select RAM.
- R7: A control write of data 0x0 or 0x1E988 clears the lock from the next clock edge, which restores RAM writes.
- R8: A control write of any other data leaves the lock unchanged.
- R9: Reset clears the lock, so RAM is writable after reset.
- R10: Every other address is unmapped: region code 0, offset 0 and the unmapped flag high. The unmapped flag is high exactly when a valid access has region code 0. With no valid access, region is 0 and the flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word |
| acc_addr | input | 32 | Access address |
| acc_wdata | input | 32 | Write data |
| region_o | output | 3 | 0 none, 1 RAM, 2 ROM, 3 scratchpad, 4 I/O, 5 control |
| offset_o | output | 21 | Byte offset inside the selected region |
| unmapped_o | output | 1 | Valid access that hits no region |

## Verification
The only hidden state is the lock flag. If it is wrong, nothing shows at the ports until the next RAM write, which then lands in the RAM region when it should be unmapped, or the other way round. For this reason, every control write in the bench is followed by a RAM write one cycle later. The magic-value, wrong-size, wrong-address and reset cases are each followed the same way. Window-edge addresses and their near misses show mirror and wrap errors on the offset and region in the same cycle.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
  typedef enum logic [2:0] {
    REG_NONE = 3'd0,
    REG_RAM  = 3'd1,
    REG_ROM  = 3'd2,
    REG_SCR  = 3'd3,
    REG_IO   = 3'd4,
    REG_CTL  = 3'd5
  } region_e;

  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [31:0] LOCK_SET_A = 32'h0000_0800;
  localparam logic [31:0] LOCK_SET_B = 32'h0000_0804;
  localparam logic [31:0] LOCK_CLR_A = 32'h0000_0000;
  localparam logic [31:0] LOCK_CLR_B = 32'h0001_E988;
endpackage

// File: rtl/mirror_window.sv
module mirror_window #(
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] BASE       = 32'h0,
  parameter int          SPAN_BYTES = 4096,
  parameter int          WRAP_BYTES = 4096,
  parameter int          OFF_W      = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [OFF_W-1:0]  offset
);
  localparam logic [ADDR_W-1:0] SPAN_MASK = ~(ADDR_W'(SPAN_BYTES) - 1'b1);
  localparam logic [ADDR_W-1:0] WRAP_MASK = ADDR_W'(WRAP_BYTES) - 1'b1;

  always_comb begin
    hit    = (((addr ^ BASE[ADDR_W-1:0]) & SPAN_MASK) == '0);
    offset = OFF_W'(addr & WRAP_MASK);
  end
endmodule

// File: rtl/ram_lock_reg.sv
module ram_lock_reg
  import mdec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              lock_q
);
  logic lock_d;
  logic is_set;
  logic is_clr;

  always_comb begin
    is_set = (wdata == LOCK_SET_A[DATA_W-1:0]) || (wdata == LOCK_SET_B[DATA_W-1:0]);
    is_clr = (wdata == LOCK_CLR_A[DATA_W-1:0]) || (wdata == LOCK_CLR_B[DATA_W-1:0]);
    lock_d = lock_q;
    if (ctl_wr) begin
      if (is_set)      lock_d = 1'b1;
      else if (is_clr) lock_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lock_q <= 1'b0;
    else if (ctl_wr) lock_q <= lock_d;
  end

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr || !(is_set || is_clr)) |=> $stable(lock_q));
  // R6
  lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && (wdata == LOCK_SET_A[DATA_W-1:0] || wdata == LOCK_SET_B[DATA_W-1:0])) |=> lock_q);
  // R7
  lock_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && (wdata == LOCK_CLR_A[DATA_W-1:0] || wdata == LOCK_CLR_B[DATA_W-1:0])) |=> !lock_q);
endmodule

// File: rtl/mirror_decoder.sv
module mirror_decoder
  import mdec_pkg::*;
#(
  parameter int                  ADDR_W        = 32,
  parameter int                  RAM_BYTES     = 2 * 1024 * 1024,
  parameter int                  RAM_WIN_BYTES = 8 * 1024 * 1024,
  parameter int                  N_RAM         = 3,
  parameter logic [N_RAM*32-1:0] RAM_BASES     = {32'hA000_0000, 32'h8000_0000, 32'h0000_0000},
  parameter int                  ROM_BYTES     = 512 * 1024,
  parameter int                  N_ROM         = 2,
  parameter logic [N_ROM*32-1:0] ROM_BASES     = {32'hBFC0_0000, 32'h1FC0_0000},
  parameter int                  PAGE_BYTES    = 4096,
  parameter logic [31:0]         SCR_BASE      = 32'h1F80_0000,
  parameter logic [31:0]         IO_BASE       = 32'h1F80_1000,
  parameter logic [31:0]         CTL_ADDR      = 32'hFFFE_0130,
  parameter int                  OFF_W         = $clog2(RAM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        acc_size,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic [2:0]        region_o,
  output logic [OFF_W-1:0]  offset_o,
  output logic              unmapped_o
);
  logic [1:0] rst_sync;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  logic [N_RAM-1:0]             ram_hits;
  logic [N_RAM-1:0][OFF_W-1:0]  ram_offs;
  logic [N_ROM-1:0]             rom_hits;
  logic [N_ROM-1:0][OFF_W-1:0]  rom_offs;

  for (genvar g = 0; g < N_RAM; g++) begin : g_ram
    mirror_window #(
      .ADDR_W(ADDR_W), .BASE(RAM_BASES[g*32 +: 32]),
      .SPAN_BYTES(RAM_WIN_BYTES), .WRAP_BYTES(RAM_BYTES), .OFF_W(OFF_W)
    ) i_win (.addr(acc_addr), .hit(ram_hits[g]), .offset(ram_offs[g]));
  end

  for (genvar g = 0; g < N_ROM; g++) begin : g_rom
    mirror_window #(
      .ADDR_W(ADDR_W), .BASE(ROM_BASES[g*32 +: 32]),
      .SPAN_BYTES(ROM_BYTES), .WRAP_BYTES(ROM_BYTES), .OFF_W(OFF_W)
    ) i_win (.addr(acc_addr), .hit(rom_hits[g]), .offset(rom_offs[g]));
  end

  logic             scr_hit, io_hit;
  logic [OFF_W-1:0] scr_off, io_off;

  mirror_window #(
    .ADDR_W(ADDR_W), .BASE(SCR_BASE),
    .SPAN_BYTES(PAGE_BYTES), .WRAP_BYTES(PAGE_BYTES), .OFF_W(OFF_W)
  ) i_scr (.addr(acc_addr), .hit(scr_hit), .offset(scr_off));

  mirror_window #(
    .ADDR_W(ADDR_W), .BASE(IO_BASE),
    .SPAN_BYTES(PAGE_BYTES), .WRAP_BYTES(PAGE_BYTES), .OFF_W(OFF_W)
  ) i_io (.addr(acc_addr), .hit(io_hit), .offset(io_off));

  logic ctl_wr;
  logic lock_q;
  logic ram_hit, rom_hit;
  logic [OFF_W-1:0] ram_off, rom_off;

  always_comb begin
    ram_hit = |ram_hits;
    rom_hit = |rom_hits;
    ram_off = '0;
    rom_off = '0;
    for (int i = 0; i < N_RAM; i++) if (ram_hits[i]) ram_off = ram_offs[i];
    for (int i = 0; i < N_ROM; i++) if (rom_hits[i]) rom_off = rom_offs[i];
    ctl_wr = acc_valid && acc_write && (acc_size == SZ_WORD) &&
             (acc_addr == CTL_ADDR[ADDR_W-1:0]);
  end

  ram_lock_reg #(.DATA_W(32)) i_lock (
    .clk(clk), .rst_n(rst_sync_n), .ctl_wr(ctl_wr),
    .wdata(acc_wdata), .lock_q(lock_q)
  );

  region_e region;

  always_comb begin
    region   = REG_NONE;
    offset_o = '0;
    if (acc_valid) begin
      if (ram_hit) begin
        if (!(acc_write && lock_q)) begin
          region   = REG_RAM;
          offset_o = ram_off;
        end
      end else if (rom_hit) begin
        if (!acc_write) begin
          region   = REG_ROM;
          offset_o = rom_off;
        end
      end else if (scr_hit) begin
        region   = REG_SCR;
        offset_o = scr_off;
      end else if (io_hit) begin
        region   = REG_IO;
        offset_o = io_off;
      end else if (ctl_wr) begin
        region   = REG_CTL;
      end
    end
    region_o   = region;
    unmapped_o = acc_valid && (region == REG_NONE);
  end

  // R6
  discard_wr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_valid && acc_write && lock_q) |-> (region_o != REG_RAM));
  // R2
  rom_ro_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_valid && acc_write) |-> (region_o != REG_ROM));
  // R10
  win_overlap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({ram_hit, rom_hit, scr_hit, io_hit}));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !acc_valid |-> (region_o == REG_NONE && !unmapped_o));
endmodule

// File: tb/test_mirror_decoder.sv
`timescale 1ns/1ps
module test_mirror_decoder;
  typedef struct {
    logic [2:0]  reg_e;
    logic [20:0] off_e;
    logic        unm_e;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [1:0]  acc_size = 2'd2;
  logic [31:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [2:0]  region_o;
  logic [20:0] offset_o;
  logic        unmapped_o;

  int checks = 0;
  int errors = 0;
  bit model_lock = 1'b0;
  bit done = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  mirror_decoder i_mirror_decoder (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_size(acc_size), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .region_o(region_o), .offset_o(offset_o), .unmapped_o(unmapped_o)
  );

  function automatic exp_t model(bit v, bit w, logic [1:0] sz, logic [31:0] a,
                                 logic [31:0] d, bit lk, string tag);
    exp_t e;
    logic [2:0] s;
    e.reg_e = 3'd0; e.off_e = '0; e.tag = tag;
    s = a[31:29];
    if (v) begin
      if ((s == 3'b000 || s == 3'b100 || s == 3'b101) && a[28:23] == 6'd0) begin
        if (!(w && lk)) begin e.reg_e = 3'd1; e.off_e = a[20:0]; end
      end else if ((a[31:19] == 13'h03F8 || a[31:19] == 13'h17F8)) begin
        if (!w) begin e.reg_e = 3'd2; e.off_e = {2'b0, a[18:0]}; end
      end else if (a[31:12] == 20'h1F800) begin
        e.reg_e = 3'd3; e.off_e = {9'b0, a[11:0]};
      end else if (a[31:12] == 20'h1F801) begin
        e.reg_e = 3'd4; e.off_e = {9'b0, a[11:0]};
      end else if (w && sz == 2'd2 && a == 32'hFFFE_0130) begin
        e.reg_e = 3'd5;
      end
    end
    e.unm_e = v && (e.reg_e == 3'd0);
    if (d == 32'hx) e.tag = tag;
    return e;
  endfunction

  task automatic acc(bit w, logic [1:0] sz, logic [31:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_size = sz; acc_addr = a; acc_wdata = d;
    q.push_back(model(1'b1, w, sz, a, d, model_lock, tag));
    if (w && sz == 2'd2 && a == 32'hFFFE_0130) begin
      if (d == 32'h800 || d == 32'h804) model_lock = 1'b1;
      else if (d == 32'h0 || d == 32'h1E988) model_lock = 1'b0;
    end
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    q.push_back(model(1'b0, 1'b0, 2'd2, acc_addr, 32'h0, model_lock, tag));
  endtask

  task automatic do_reset();
    @(negedge clk);
    acc_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_lock = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  always @(negedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (region_o !== e.reg_e || offset_o !== e.off_e || unmapped_o !== e.unm_e) begin
        errors++;
        $display("FAIL %s: got region=%0d off=%h unm=%b expected region=%0d off=%h unm=%b",
                 e.tag, region_o, offset_o, unmapped_o, e.reg_e, e.off_e, e.unm_e);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle("R10 idle after reset");
    acc(1, 2, 32'h0000_1234, 32'h1, "R9 RAM writable after reset");
    acc(1, 2, 32'h8020_0010, 32'h1, "R1 kseg0 mirror wrap");
    acc(0, 2, 32'hA07F_FFFC, 32'h0, "R1 kseg1 top of window");
    acc(0, 2, 32'h0080_0000, 32'h0, "R10 just past RAM window");
    acc(0, 1, 32'h1FC0_0100, 32'h0, "R2 ROM low base read");
    acc(0, 0, 32'hBFC7_FFFF, 32'h0, "R2 ROM high base last byte");
    acc(1, 2, 32'h1FC0_0000, 32'h5, "R2 ROM write unmapped");
    acc(0, 2, 32'h9FC0_0000, 32'h0, "R10 no ROM mirror in cached seg");
    acc(1, 0, 32'h1F80_0ABC, 32'h7, "R3 scratchpad write");
    acc(0, 2, 32'h1F80_0FFC, 32'h0, "R3 scratchpad read");
    acc(1, 1, 32'h1F80_1FFE, 32'h7, "R4 IO page");
    acc(0, 2, 32'h1F80_2000, 32'h0, "R10 past IO page");
    acc(1, 2, 32'hFFFE_0130, 32'h800, "R5 R6 control write set");
    acc(1, 2, 32'h0000_0000, 32'h1, "R6 lock kuseg write");
    acc(1, 0, 32'h8000_0004, 32'h1, "R6 lock kseg0 write");
    acc(1, 1, 32'hA010_0000, 32'h1, "R6 lock kseg1 write");
    acc(0, 2, 32'h8000_0040, 32'h0, "R6 read while locked");
    acc(1, 2, 32'hFFFE_0130, 32'h1234, "R8 other value");
    acc(1, 2, 32'h0000_0100, 32'h1, "R8 still locked");
    acc(1, 2, 32'hFFFE_0134, 32'h0, "R5 other page address");
    acc(1, 2, 32'h0000_0100, 32'h1, "R5 still locked after page write");
    acc(1, 0, 32'hFFFE_0130, 32'h0, "R5 byte control write");
    acc(1, 2, 32'h0000_0100, 32'h1, "R5 still locked after byte write");
    acc(0, 2, 32'hFFFE_0130, 32'h0, "R5 control read");
    acc(1, 2, 32'h0000_0100, 32'h1, "R5 still locked after read");
    acc(1, 2, 32'hFFFE_0130, 32'h1E988, "R7 clear alt value");
    acc(1, 2, 32'h0010_0000, 32'h1, "R7 RAM writable again");
    acc(1, 2, 32'hFFFE_0130, 32'h804, "R6 set alt value");
    acc(1, 2, 32'hA000_0000, 32'h1, "R6 locked after alt set");
    acc(1, 2, 32'hFFFE_0130, 32'h0, "R7 clear zero");
    acc(1, 2, 32'hA000_0000, 32'h1, "R7 unlocked after zero");
    acc(1, 2, 32'hFFFE_0130, 32'h800, "R6 set before reset");
    do_reset();
    acc(1, 2, 32'h8000_0000, 32'h1, "R9 reset clears lock");
    idle("R10 idle at end");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule